// File: doc/BRIEF.md
# CRC32C Accumulator

This block advances a running 32-bit cyclic redundancy check over the Castagnoli generator 0x11EDC6F41. Each operation merges one data chunk into the CRC. The chunk is 8, 16, 32 or 64 bits wide, chosen per operation. The CRC is processed in reflected order: data bits enter least-significant first and the reversed polynomial 0x82F63B78 is applied. The block never complements the CRC. Any seeding with all ones, and any final inversion, belongs to the surrounding logic.

A controller pulses `start_i` with the old CRC, the data word and the size code. The block returns the new CRC in the low half of a 64-bit result whose upper half is always zero, and pulses `done_o` when it is ready. The result stays in a register until the next operation finishes. A buffer is streamed by feeding `result_o[31:0]` back in as `crc_i` on the next start.

Narrow sizes finish in one cycle. A 64-bit chunk passes through the same 32-bit folding stage twice: the low half is folded first, then the high half.

Top module: `crc32c_accum`

## Requirements
- R1: After reset, `result_o` is zero and `done_o` is low.
- R2: The update is a reflected CRC-32C. For each data bit, least-significant first, the feedback is `crc[0]` XOR the data bit. The CRC shifts right by one, and 0x82F63B78 is XORed in when the feedback is 1.
- R3: `size_i` encodings are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. The chunk is the low bits of `data_i`, and data bits above the chosen size have no effect on the result.
- R4: The old CRC is taken from `crc_i` when the operation is accepted. A change to `crc_i` or `data_i` after acceptance has no effect on that operation.
- R5: `result_o[63:32]` is zero at all times.
- R6: For sizes 0, 1 and 2, a start sampled at a clock edge shows the new CRC on `result_o` and raises `done_o` immediately after that same edge.
- R7: For size 3, `done_o` stays low after the accepting edge and rises after the following edge, together with the final CRC.
- R8: A start sampled at the second cycle of a 64-bit operation is ignored.
- R9: `done_o` is high only in the cycle after an operation completes. With no start, `result_o` holds its value.
- R10: No inversion is applied internally. A zero CRC with zero data gives zero. Seeding with 0xFFFFFFFF, streaming the ASCII string "123456789" and inverting the result externally gives 0xE3069283.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins an operation when the unit is idle |
| size_i | input | 2 | Chunk size code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| crc_i | input | 32 | Old CRC, the low half of the destination operand |
| data_i | input | 64 | Data chunk, right-aligned |
| result_o | output | 64 | New CRC, zero-extended |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
For a narrow size, the new CRC and `done_o` appear right after the rising edge that samples `start_i`. For a 64-bit chunk they appear one edge later, and any start offered in between is dropped. The bench drives inputs on falling edges. It steps a behavioural bit-serial model on each rising edge, with the same one-cycle or two-cycle timing, and compares `result_o` and `done_o` with the model at every falling edge. After each operation the bench also scrambles the inputs, which shows that the result is not sampled again.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int          CRC_W     = 32;
    localparam logic [31:0] POLY_REFL = 32'h82F63B78;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } crc_size_e;

    typedef struct packed {
        logic             wide;   // second half of a 64-bit chunk pending
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] hi;     // stored upper data half
        logic             done;
    } acc_state_t;

endpackage

// File: rtl/crc32c_fold.sv
module crc32c_fold
    import crc32c_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [W-1:0]     data_in,
    output logic [CRC_W-1:0] crc_out
);

    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < W; i++) begin
            fb = c[0] ^ data_in[i];
            c  = {1'b0, c[CRC_W-1:1]} ^ (fb ? POLY_REFL : '0);
        end
        crc_out = c;
    end

endmodule

// File: rtl/crc32c_size_pick.sv
module crc32c_size_pick
    import crc32c_pkg::*;
(
    input  logic [1:0]       size_i,
    input  logic [CRC_W-1:0] c8_i,
    input  logic [CRC_W-1:0] c16_i,
    input  logic [CRC_W-1:0] c32_i,
    output logic [CRC_W-1:0] crc_o
);

    always_comb begin
        case (crc_size_e'(size_i))
            SZ_8:    crc_o = c8_i;
            SZ_16:   crc_o = c16_i;
            default: crc_o = c32_i;  // 32 bits, or the first half of 64
        endcase
    end

endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum
    import crc32c_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o
);

    localparam int HALF   = DATA_W / 2;
    localparam int N_NARR = 2;

    acc_state_t st_d, st_q;

    logic [N_NARR-1:0][CRC_W-1:0] narrow_crc;
    logic [CRC_W-1:0]             f32_crc_in;
    logic [HALF-1:0]              f32_data_in;
    logic [CRC_W-1:0]             f32_out;
    logic [CRC_W-1:0]             picked;
    logic                         wide_q;

    // 8- and 16-bit folding stages
    for (genvar g = 0; g < N_NARR; g++) begin : g_narrow
        localparam int W = 8 << g;
        crc32c_fold #(.W(W)) u_fold (
            .crc_in  (crc_i),
            .data_in (data_i[W-1:0]),
            .crc_out (narrow_crc[g])
        );
    end

    // One 32-bit stage, reused for the second half of a 64-bit chunk
    assign f32_crc_in  = st_q.wide ? st_q.crc : crc_i;
    assign f32_data_in = st_q.wide ? st_q.hi  : data_i[HALF-1:0];

    crc32c_fold #(.W(HALF)) u_fold32 (
        .crc_in  (f32_crc_in),
        .data_in (f32_data_in),
        .crc_out (f32_out)
    );

    crc32c_size_pick u_pick (
        .size_i (size_i),
        .c8_i   (narrow_crc[0]),
        .c16_i  (narrow_crc[1]),
        .c32_i  (f32_out),
        .crc_o  (picked)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.wide) begin
            st_d.crc  = f32_out;
            st_d.wide = 1'b0;
            st_d.done = 1'b1;
        end else if (start_i) begin
            st_d.crc = picked;
            if (crc_size_e'(size_i) == SZ_64) begin
                st_d.wide = 1'b1;
                st_d.hi   = data_i[DATA_W-1:HALF];
            end else begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wide_q   = st_q.wide;
    assign result_o = {{(DATA_W-CRC_W){1'b0}}, st_q.crc};
    assign done_o   = st_q.done;

endmodule

// File: rtl/crc32c_accum_chk.sv
module crc32c_accum_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [1:0]  size_i,
    input logic [63:0] result_o,
    input logic        done_o,
    input logic        wide_q
);

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_o[63:32] == 32'h0);

    assert_narrow_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i != 2'd3 && !wide_q) |=> done_o);

    assert_wide_first_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i == 2'd3 && !wide_q) |=> (wide_q && !done_o));

    assert_wide_finishes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wide_q |=> (done_o && !wide_q));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !wide_q) |=> (!done_o && $stable(result_o)));

endmodule

bind crc32c_accum crc32c_accum_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .size_i   (size_i),
    .result_o (result_o),
    .done_o   (done_o),
    .wide_q   (wide_q)
);

// File: tb/test_crc32c_accum.sv
module test_crc32c_accum;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [31:0] crc_in = 32'h0;
    logic [63:0] data = 64'h0;
    logic [63:0] result;
    logic        done;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    crc32c_accum i_crc32c_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .size_i   (size),
        .crc_i    (crc_in),
        .data_i   (data),
        .result_o (result),
        .done_o   (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: bit-serial reflected CRC-32C
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [63:0] d, input int n);
        int unsigned v = c;
        for (int i = 0; i < n; i++) begin
            v = v ^ int'(d[i]);
            if (v % 2 == 1) v = (v >> 1) ^ 32'h82F63B78;
            else            v = v >> 1;
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Cycle model
    logic        m_done, m_pend;
    logic [31:0] m_res, m_hi;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_done <= 1'b0; m_pend <= 1'b0; m_res <= '0; m_hi <= '0;
        end else begin
            m_done <= 1'b0;
            if (m_pend) begin
                m_res  <= ref_crc(m_res, {32'h0, m_hi}, 32);
                m_done <= 1'b1;
                m_pend <= 1'b0;
            end else if (start) begin
                case (size)
                    2'd0: m_res <= ref_crc(crc_in, data, 8);
                    2'd1: m_res <= ref_crc(crc_in, data, 16);
                    2'd2: m_res <= ref_crc(crc_in, data, 32);
                    default: begin
                        m_res  <= ref_crc(crc_in, data, 32);
                        m_hi   <= data[63:32];
                        m_pend <= 1'b1;
                    end
                endcase
                if (size != 2'd3) m_done <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " result"}, result, {32'h0, m_res});
            chk({cur_req, " done"}, {63'h0, done}, {63'h0, m_done});
        end
    end

    task automatic do_op(input logic [1:0] sz, input logic [31:0] c, input logic [63:0] d);
        @(negedge clk);
        start = 1'b1; size = sz; crc_in = c; data = d;
        @(negedge clk);
        start = 1'b0; crc_in = ~c; data = ~d;   // R4: changes after acceptance
        if (sz == 2'd3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] acc;
        idle(3);
        chk("R1 reset result", result, 64'h0);
        chk("R1 reset done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R6";
        do_op(2'd0, 32'hFFFFFFFF, 64'h31);
        do_op(2'd1, 32'h12345678, 64'hBEEF);
        do_op(2'd2, 32'hA5A5A5A5, 64'hDEADBEEF);

        cur_req = "R3";
        do_op(2'd0, 32'h0BADF00D, 64'hFFFF_FFFF_FFFF_FF5A);
        do_op(2'd1, 32'h0BADF00D, 64'h1234_5678_9ABC_C35A);
        chk("R5 upper half", {32'h0, result[63:32]}, 64'h0);

        cur_req = "R7";
        do_op(2'd3, 32'hFFFFFFFF, 64'h0123_4567_89AB_CDEF);

        cur_req = "R8";
        @(negedge clk);
        start = 1'b1; size = 2'd3; crc_in = 32'h11111111; data = 64'hCAFE_F00D_1234_5678;
        @(negedge clk);
        size = 2'd0; crc_in = 32'h22222222; data = 64'h77;   // offered in the second cycle
        @(negedge clk);
        start = 1'b0;
        idle(1);

        cur_req = "R9";
        idle(3);
        @(negedge clk);
        start = 1'b1; size = 2'd0; crc_in = 32'h1; data = 64'h2;
        @(negedge clk);
        size = 2'd1; crc_in = 32'h3; data = 64'h4;
        @(negedge clk);
        size = 2'd2; crc_in = 32'h5; data = 64'h6;
        @(negedge clk);
        start = 1'b0;
        idle(3);

        cur_req = "R10";
        do_op(2'd2, 32'h0, 64'h0);
        chk("R10 zero in zero out", result, 64'h0);
        do_op(2'd3, 32'hFFFFFFFF, 64'h3837363534333231);
        acc = result[31:0];
        do_op(2'd0, acc, 64'h39);
        chk("R10 check value", {32'h0, ~result[31:0]}, 64'hE3069283);

        cur_req = "R2";
        for (int k = 0; k < 40; k++) begin
            do_op(2'(k % 4), $urandom, {$urandom, $urandom});
            if (k % 5 == 0) idle(1);
        end
        idle(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule